// File: doc/BRIEF.md
# Pin I/O Controller with Interrupt Line Routing

This block is a register-mapped general-purpose pin controller. Software writes 32-bit registers to set per-pin output levels and output drivers, and reads a register that returns the pin levels after a two-flop synchroniser. The register port is a plain address / write-data / write-strobe / read-data interface. Writes land on the clock edge that samples the strobe. Reads are combinational from the addressed register.

A fixed window of consecutive pins can be routed to a parent interrupt controller, one interrupt line per pin. Each pin owns a 2-bit field in a function-select register, and the low bit of the field (bit 2×pin) enables the interrupt role. A per-line polarity bit normalises the pin so that the parent always sees an active-high request. Latching, masking and acknowledging are left to the parent.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq_out` is zero.
- R2: Register offsets: line polarity 0x290, function select 0x294, output enable 0x29C, output data 0x2A0, input levels 0x2A4. Any other offset reads zero, and writes to it change no register.
- R3: A write takes effect at the clock edge that samples `reg_we` high, and is not visible before that edge. Read data follows `reg_addr` combinationally.
- R4: The output-enable and output-data registers hold one bit per pin at bit position `pin`. `pin_oe` and `pin_out` mirror them. Bits at or above NUM_PINS are discarded and read zero.
- R5: The input-level register shows `pin_in` delayed by two clock edges. A pin change is not visible after one edge and is visible after two.
- R6: Interrupt line n serves pin IRQ_BASE+n. The line is active only while bit 2×(IRQ_BASE+n) of the function-select register is 1. Clearing that bit forces the line low. The odd bit of the field does not enable it.
- R7: With polarity bit n = 1 the line is high when the synchronised pin is high. With polarity bit n = 0 the line is high when the pin is low.
- R8: Pins outside the interrupt window never raise a line, even when their select bit is set. Polarity bits at or above NUM_IRQ are discarded and read zero.
- R9: The function-select register stores and returns all 32 written bits, so read-modify-write by software is lossless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | NUM_PINS | Raw pin levels (asynchronous) |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output driver enables |
| irq_out | output | NUM_IRQ | Active-high interrupt lines to the parent |

## Verification
The bench builds the block with its default parameters: 22 pins, and 6 interrupt lines starting at pin 8. With these values the select bits of the window sit at 16 to 26 inside one 32-bit register, and the upper ten pin bits and upper 26 polarity bits can be shown to be discarded. Select fields of pins below and above the window also have real bit positions to set. So it can be shown that they raise nothing.

// File: rtl/gpio_irq_mux_pkg.sv
package gpio_irq_mux_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    localparam logic [OFF_W-1:0] OFF_POL  = 12'h290;
    localparam logic [OFF_W-1:0] OFF_FUNC = 12'h294;
    localparam logic [OFF_W-1:0] OFF_OE   = 12'h29C;
    localparam logic [OFF_W-1:0] OFF_OUT  = 12'h2A0;
    localparam logic [OFF_W-1:0] OFF_IN   = 12'h2A4;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_POL,
        RS_FUNC,
        RS_OE,
        RS_OUT,
        RS_IN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e target;
        logic     wr;
    } reg_access_t;

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        reg_sel_e r;
        case (off)
            OFF_POL:  r = RS_POL;
            OFF_FUNC: r = RS_FUNC;
            OFF_OE:   r = RS_OE;
            OFF_OUT:  r = RS_OUT;
            OFF_IN:   r = RS_IN;
            default:  r = RS_NONE;
        endcase
        return r;
    endfunction

    // Select bit that puts a pin in interrupt role.
    function automatic int func_bit(input int pin);
        return 2 * pin;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 22,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PINS = 22,
    parameter int NUM_IRQ  = 6,
    parameter int IRQ_BASE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFF_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_we,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] in_sync,
    output logic [NUM_PINS-1:0] oe_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_IRQ-1:0]  pol_q,
    output logic [NUM_IRQ-1:0]  line_en
);
    logic [DATA_W-1:0] func_q;
    reg_access_t       acc;

    always_comb begin
        acc.target = decode_offset(reg_addr);
        acc.wr     = reg_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '0;
            func_q <= '0;
            oe_q   <= '0;
            out_q  <= '0;
        end else if (acc.wr) begin
            case (acc.target)
                RS_POL:  pol_q  <= reg_wdata[NUM_IRQ-1:0];
                RS_FUNC: func_q <= reg_wdata;
                RS_OE:   oe_q   <= reg_wdata[NUM_PINS-1:0];
                RS_OUT:  out_q  <= reg_wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (acc.target)
            RS_POL:  reg_rdata[NUM_IRQ-1:0]  = pol_q;
            RS_FUNC: reg_rdata               = func_q;
            RS_OE:   reg_rdata[NUM_PINS-1:0] = oe_q;
            RS_OUT:  reg_rdata[NUM_PINS-1:0] = out_q;
            RS_IN:   reg_rdata[NUM_PINS-1:0] = in_sync;
            default: reg_rdata               = '0;
        endcase
    end

    genvar n;
    generate
        for (n = 0; n < NUM_IRQ; n++) begin : g_en
            localparam int SB = func_bit(IRQ_BASE + n);
            assign line_en[n] = func_q[SB];
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int NUM_IRQ = 6
) (
    input  logic [NUM_IRQ-1:0] win_level,
    input  logic [NUM_IRQ-1:0] line_en,
    input  logic [NUM_IRQ-1:0] pol_q,
    output logic [NUM_IRQ-1:0] irq_out
);
    genvar n;
    generate
        for (n = 0; n < NUM_IRQ; n++) begin : g_line
            logic active;
            // polarity 1: pass level; polarity 0: invert level
            assign active     = win_level[n] ^ ~pol_q[n];
            assign irq_out[n] = line_en[n] & active;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PINS = 22,
    parameter int NUM_IRQ  = 6,
    parameter int IRQ_BASE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFF_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_we,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_IRQ-1:0]  irq_out
);
    localparam int SYNC_STAGES = 2;

    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_IRQ-1:0]  line_en;
    logic [NUM_IRQ-1:0]  line_pol;

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_regfile #(
        .NUM_PINS (NUM_PINS),
        .NUM_IRQ  (NUM_IRQ),
        .IRQ_BASE (IRQ_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .in_sync   (in_sync),
        .oe_q      (pin_oe),
        .out_q     (pin_out),
        .pol_q     (line_pol),
        .line_en   (line_en)
    );

    gpio_irq_route #(
        .NUM_IRQ (NUM_IRQ)
    ) u_route (
        .win_level (in_sync[IRQ_BASE +: NUM_IRQ]),
        .line_en   (line_en),
        .pol_q     (line_pol),
        .irq_out   (irq_out)
    );
endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk
    import gpio_irq_mux_pkg::*;
#(
    parameter int NUM_PINS = 22,
    parameter int NUM_IRQ  = 6
) (
    input logic                clk,
    input logic                rst,
    input logic [OFF_W-1:0]    reg_addr,
    input logic [NUM_PINS-1:0] wdata_pins,
    input logic                reg_we,
    input logic [NUM_IRQ-1:0]  win_in,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_IRQ-1:0]  irq_out,
    input logic [NUM_IRQ-1:0]  line_en,
    input logic [NUM_IRQ-1:0]  line_pol
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_out == '0 && pin_oe == '0));

    a_r3_oe_write_lands: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFF_OE) |=> pin_oe == $past(wdata_pins));

    a_r6_unselected_low: assert property (@(posedge clk) disable iff (rst)
        (irq_out & ~line_en) == '0);

    genvar n;
    generate
        for (n = 0; n < NUM_IRQ; n++) begin : g_line
            a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
                (since_rst >= 2 && line_en[n]) |->
                    irq_out[n] == (line_pol[n] ? $past(win_in[n], 2) : !$past(win_in[n], 2)));
        end
    endgenerate
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .wdata_pins (reg_wdata[NUM_PINS-1:0]),
    .reg_we     (reg_we),
    .win_in     (pin_in[IRQ_BASE +: NUM_IRQ]),
    .pin_oe     (pin_oe),
    .irq_out    (irq_out),
    .line_en    (line_en),
    .line_pol   (line_pol)
);

// File: tb/sim_gpio_irq_mux.sv
module sim_gpio_irq_mux;
    import gpio_irq_mux_pkg::*;

    localparam int CLK_P    = 10;
    localparam int NUM_PINS = 22;
    localparam int NUM_IRQ  = 6;
    localparam int IRQ_BASE = 8;
    localparam int NVEC     = 8;

    // window enables, polarities, window pin levels, expected lines
    localparam logic [5:0] V_EN  [NVEC] = '{6'h3F, 6'h3F, 6'h3F, 6'h3F, 6'h15, 6'h3F, 6'h00, 6'h2A};
    localparam logic [5:0] V_POL [NVEC] = '{6'h3F, 6'h3F, 6'h00, 6'h00, 6'h3F, 6'h0F, 6'h3F, 6'h33};
    localparam logic [5:0] V_LVL [NVEC] = '{6'h3F, 6'h00, 6'h00, 6'h3F, 6'h3F, 6'h05, 6'h3F, 6'h21};
    localparam logic [5:0] V_EXP [NVEC] = '{6'h3F, 6'h00, 6'h3F, 6'h00, 6'h15, 6'h35, 6'h00, 6'h28};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [OFF_W-1:0]    reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic                reg_we = 1'b0;
    logic [DATA_W-1:0]   reg_rdata;
    logic [NUM_PINS-1:0] pin_in = '0;
    logic [NUM_PINS-1:0] pin_out;
    logic [NUM_PINS-1:0] pin_oe;
    logic [NUM_IRQ-1:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_mux #(
        .NUM_PINS (NUM_PINS),
        .NUM_IRQ  (NUM_IRQ),
        .IRQ_BASE (IRQ_BASE)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [OFF_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [OFF_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] sel_word(input logic [5:0] en);
        logic [31:0] s = '0;
        for (int n = 0; n < NUM_IRQ; n++)
            if (en[n]) s[2*(IRQ_BASE+n)] = 1'b1;
        return s;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(OFF_POL, v);  check("R1 pol reset", v, 0);
        rd(OFF_FUNC, v); check("R1 func reset", v, 0);
        rd(OFF_OE, v);   check("R1 oe reset", v, 0);
        rd(OFF_OUT, v);  check("R1 out reset", v, 0);
        rd(OFF_IN, v);   check("R1 in reset", v, 0);
        check("R1 pins", {pin_oe, pin_out}, 0);
        check("R1 irq", 32'(irq_out), 0);

        // R4 oe width mask and mirror
        wr(OFF_OE, 32'hFFFF_FFFF);
        rd(OFF_OE, v); check("R4 oe readback", v, 32'h003F_FFFF);
        check("R4 pin_oe", 32'(pin_oe), 32'h003F_FFFF);

        // R3 write visible only after the edge
        @(negedge clk);
        reg_addr = OFF_OUT; reg_wdata = 32'hA5A5_A5A5; reg_we = 1'b1;
        #1 check("R3 before edge", reg_rdata, 0);
        @(negedge clk);
        reg_we = 1'b0;
        #1 check("R3 after edge", reg_rdata, 32'h0025_A5A5);
        check("R4 pin_out", 32'(pin_out), 32'h0025_A5A5);

        // R2 undefined offsets
        wr(12'h298, 32'hFFFF_FFFF);
        rd(12'h298, v); check("R2 hole 0x298", v, 0);
        rd(12'h000, v); check("R2 offset 0", v, 0);
        rd(OFF_OUT, v); check("R2 out untouched", v, 32'h0025_A5A5);
        rd(OFF_POL, v); check("R2 pol untouched", v, 0);

        // R9 select register keeps all bits
        wr(OFF_FUNC, 32'hDEAD_BEEF);
        rd(OFF_FUNC, v); check("R9 func readback", v, 32'hDEAD_BEEF);
        wr(OFF_FUNC, 32'h0);

        // R5 two-edge input synchroniser
        @(negedge clk);
        pin_in = 22'h2A_AAAA;
        reg_addr = OFF_IN;
        @(negedge clk);
        #1 check("R5 after one edge", reg_rdata, 0);
        @(negedge clk);
        #1 check("R5 after two edges", reg_rdata, 32'h002A_AAAA);

        // R8 polarity width mask
        wr(OFF_POL, 32'hFFFF_FFFF);
        rd(OFF_POL, v); check("R8 pol mask", v, 32'h0000_003F);

        // R8 pins outside window never raise a line
        wr(OFF_FUNC, 32'h5555_5555);
        @(negedge clk);
        pin_in = 22'h3F_C0FF;
        repeat (3) @(negedge clk);
        check("R8 outside window", 32'(irq_out), 0);

        // R6 odd bit of field does not select; clearing select drops line
        wr(OFF_FUNC, 32'h0002_0000);
        @(negedge clk);
        pin_in = 22'h00_0100;
        repeat (3) @(negedge clk);
        check("R6 odd bit", 32'(irq_out), 0);
        wr(OFF_FUNC, 32'h0001_0000);
        check("R6 selected", 32'(irq_out), 1);
        wr(OFF_FUNC, 32'h0);
        check("R6 cleared", 32'(irq_out), 0);

        // R7 polarity / select vectors
        for (int i = 0; i < NVEC; i++) begin
            wr(OFF_FUNC, sel_word(V_EN[i]));
            wr(OFF_POL, 32'(V_POL[i]));
            @(negedge clk);
            pin_in = NUM_PINS'(V_LVL[i]) << IRQ_BASE;
            repeat (3) @(negedge clk);
            check($sformatf("R7 vector %0d", i), 32'(irq_out), 32'(V_EXP[i]));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule